// File: doc/BRIEF.md
# USB Device Endpoint Control Register Bank

This block keeps the control settings for the endpoints of a USB device controller. Each endpoint has a receive direction and a transmit direction. Each direction has a stall flag, a transfer-type field and an enable. Endpoint 0 is always a control endpoint and is always enabled. The other endpoints are fully programmable through a simple register write port and a combinational read port. The packet engine uses the per-direction stall-handshake outputs to decide whether to answer the host with STALL.

Software sets a stall flag and it stays set. Hardware clears it on behalf of the SETUP protocol, but only for directions whose type is control. A per-endpoint guard state machine tracks the SETUP protocol and has three states:
- GRD_IDLE: no forced clear.
- GRD_HOLD: entered from any state on a SETUP pulse. It stays there while the endpoint's setup-status flag is high.
- GRD_TRAIL: entered from GRD_HOLD when the setup-status flag is seen low. It lasts `TRAIL_CYC` cycles (at most 50) and then returns to GRD_IDLE. A new SETUP pulse sends it back to GRD_HOLD.

Outside GRD_IDLE, the stall flags of control-type directions are held at zero, whatever software writes.

Top module: `usb_ep_ctrl_bank`

## Requirements
- R1: A direction's stall-handshake output is high exactly when its stall flag is set and that direction is enabled. The stall flag is written through bit 0 (receive) and bit 16 (transmit).
- R2: A set stall flag stays set across any number of idle cycles, until software writes zero to it or a SETUP clears it.
- R3: A SETUP pulse for an endpoint clears the stall flag of each of its directions whose type is control (encoding 0). It leaves the stall flags of directions with other types unchanged.
- R4: After a SETUP pulse, and for as long as that endpoint's setup-status flag stays high, software writes of one to a control-type stall flag have no effect.
- R5: After the setup-status flag is seen low, writes of one stay without effect for a further `TRAIL_CYC` cycles. After that window they set the flag again.
- R6: If a SETUP pulse and a software write of one to a control-type stall flag arrive in the same cycle, the flag ends up clear.
- R7: Register layout:
  - bit 0: receive stall
  - bits 3:2: receive type
  - bit 7: receive enable
  - bit 16: transmit stall
  - bits 19:18: transmit type
  - bit 23: transmit enable

  All other bits read as zero and ignore writes.
- R8: After reset, all stall flags are 0 and all types are control (0). The enables of endpoints 1 and up are 0.
- R9: Endpoint 0 types always read as control and both of its enables always read as 1. Writes do not change them.
- R10: For endpoints 1 and up, the type fields are read/write with the encoding 0 control, 1 isochronous, 2 bulk, 3 interrupt. They appear on the type outputs two bits per endpoint, with endpoint n at bits 2n+1:2n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the selected endpoint register |
| reg_addr | input | ADDR_W | Endpoint index of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected endpoint, combinational |
| setup_pulse | input | NUM_EP | One-cycle pulse per endpoint: SETUP packet received |
| setup_stat | input | NUM_EP | Per-endpoint setup-status flag |
| rx_stall_hs | output | NUM_EP | Receive direction must answer STALL |
| tx_stall_hs | output | NUM_EP | Transmit direction must answer STALL |
| rx_type | output | 2*NUM_EP | Receive type per endpoint |
| tx_type | output | 2*NUM_EP | Transmit type per endpoint |
| rx_en | output | NUM_EP | Receive enable per endpoint |
| tx_en | output | NUM_EP | Transmit enable per endpoint |

## Verification
A guard machine stuck outside GRD_IDLE shows at the ports as a stall flag that refuses to be set. The bench sees this on the first read after a write of one. A machine that leaves GRD_TRAIL early shows as a write that takes effect inside the window. The bench probes the window in its middle and again well past its end, so an off-by-many count is caught on the read that follows the write. A wrong priority, or a wrong type decode in the clear path, appears on the read right after the SETUP pulse: the stall handshake of the affected direction is still high, or a bulk direction has lost its stall.

// File: rtl/usb_epc_pkg.sv
package usb_epc_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_type_e;

    typedef enum logic [1:0] {
        GRD_IDLE  = 2'd0,
        GRD_HOLD  = 2'd1,
        GRD_TRAIL = 2'd2
    } grd_state_e;

    localparam int RX_STALL_B = 0;
    localparam int RX_TYPE_LO = 2;
    localparam int RX_EN_B    = 7;
    localparam int TX_STALL_B = 16;
    localparam int TX_TYPE_LO = 18;
    localparam int TX_EN_B    = 23;

    localparam logic [31:0] FIELD_MASK = 32'h008D_008D;

endpackage

// File: rtl/epc_setup_guard.sv
module epc_setup_guard
    import usb_epc_pkg::*;
#(
    parameter int TRAIL_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_pulse,
    input  logic setup_stat,
    output logic busy
);
    localparam int CNT_W = $clog2(TRAIL_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TRAIL_CYC - 1);

    grd_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GRD_IDLE: begin
                if (setup_pulse) state_d = GRD_HOLD;
            end
            GRD_HOLD: begin
                if (!setup_pulse && !setup_stat) begin
                    state_d = GRD_TRAIL;
                    cnt_d   = CNT_LOAD;
                end
            end
            GRD_TRAIL: begin
                if (setup_pulse) begin
                    state_d = GRD_HOLD;
                end else if (cnt_q == '0) begin
                    state_d = GRD_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = GRD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q != GRD_IDLE);
    end

    p_hold_while_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRD_HOLD && setup_stat) |=> (state_q == GRD_HOLD));

    p_trail_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRD_TRAIL && cnt_q == '0 && !setup_pulse) |=> (state_q == GRD_IDLE));

    p_trail_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GRD_TRAIL && cnt_q != '0 && !setup_pulse) |=>
            (state_q == GRD_TRAIL && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/epc_stall_bit.sv
module epc_stall_bit
    import usb_epc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       wr_val,
    input  logic [1:0] ep_type,
    input  logic       setup_pulse,
    input  logic       guard_busy,
    output logic       stall_q
);
    logic is_ctrl;
    logic hw_clr;

    assign is_ctrl = (ep_type == EP_CTRL);
    assign hw_clr  = is_ctrl && (setup_pulse || guard_busy);

    // hardware clear has priority over software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stall_q <= 1'b0;
        else if (hw_clr) stall_q <= 1'b0;
        else if (wr_stb) stall_q <= wr_val;
    end

    p_setup_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_pulse && ep_type == EP_CTRL) |=> !stall_q);

    p_other_type_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_pulse && ep_type != EP_CTRL && stall_q && !wr_stb) |=> stall_q);

    p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_busy && ep_type == EP_CTRL) |=> !stall_q);

    p_hw_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_pulse && wr_stb && wr_val && ep_type == EP_CTRL) |=> !stall_q);

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && !wr_stb && !setup_pulse && !guard_busy) |=> stall_q);

endmodule

// File: rtl/usb_ep_ctrl_bank.sv
module usb_ep_ctrl_bank
    import usb_epc_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int TRAIL_CYC = 50,
    parameter int ADDR_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_EP-1:0]   setup_pulse,
    input  logic [NUM_EP-1:0]   setup_stat,
    output logic [NUM_EP-1:0]   rx_stall_hs,
    output logic [NUM_EP-1:0]   tx_stall_hs,
    output logic [2*NUM_EP-1:0] rx_type,
    output logic [2*NUM_EP-1:0] tx_type,
    output logic [NUM_EP-1:0]   rx_en,
    output logic [NUM_EP-1:0]   tx_en
);
    logic [31:0]       wd;
    logic [NUM_EP-1:0] wr_sel;
    logic [NUM_EP-1:0] busy;
    logic [NUM_EP-1:0] rx_stall_a, tx_stall_a;
    logic [NUM_EP-1:0] rx_en_a, tx_en_a;
    logic [1:0]        rx_type_a [NUM_EP];
    logic [1:0]        tx_type_a [NUM_EP];

    assign wd = reg_wdata & FIELD_MASK;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        assign wr_sel[g] = reg_wr && (reg_addr == ADDR_W'(g));

        if (g == 0) begin : g_fixed
            assign rx_type_a[g] = EP_CTRL;
            assign tx_type_a[g] = EP_CTRL;
            assign rx_en_a[g]   = 1'b1;
            assign tx_en_a[g]   = 1'b1;
        end else begin : g_cfg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rx_type_a[g] <= EP_CTRL;
                    tx_type_a[g] <= EP_CTRL;
                    rx_en_a[g]   <= 1'b0;
                    tx_en_a[g]   <= 1'b0;
                end else if (wr_sel[g]) begin
                    rx_type_a[g] <= wd[RX_TYPE_LO +: 2];
                    tx_type_a[g] <= wd[TX_TYPE_LO +: 2];
                    rx_en_a[g]   <= wd[RX_EN_B];
                    tx_en_a[g]   <= wd[TX_EN_B];
                end
            end
        end

        epc_setup_guard #(.TRAIL_CYC(TRAIL_CYC)) u_guard (
            .clk         (clk),
            .rst_n       (rst_n),
            .setup_pulse (setup_pulse[g]),
            .setup_stat  (setup_stat[g]),
            .busy        (busy[g])
        );

        epc_stall_bit u_rx_stall (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_stb      (wr_sel[g]),
            .wr_val      (wd[RX_STALL_B]),
            .ep_type     (rx_type_a[g]),
            .setup_pulse (setup_pulse[g]),
            .guard_busy  (busy[g]),
            .stall_q     (rx_stall_a[g])
        );

        epc_stall_bit u_tx_stall (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_stb      (wr_sel[g]),
            .wr_val      (wd[TX_STALL_B]),
            .ep_type     (tx_type_a[g]),
            .setup_pulse (setup_pulse[g]),
            .guard_busy  (busy[g]),
            .stall_q     (tx_stall_a[g])
        );

        assign rx_type[2*g +: 2] = rx_type_a[g];
        assign tx_type[2*g +: 2] = tx_type_a[g];
    end

    assign rx_en       = rx_en_a;
    assign tx_en       = tx_en_a;
    assign rx_stall_hs = rx_stall_a & rx_en_a;
    assign tx_stall_hs = tx_stall_a & tx_en_a;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                reg_rdata[RX_STALL_B]      = rx_stall_a[i];
                reg_rdata[RX_TYPE_LO +: 2] = rx_type_a[i];
                reg_rdata[RX_EN_B]         = rx_en_a[i];
                reg_rdata[TX_STALL_B]      = tx_stall_a[i];
                reg_rdata[TX_TYPE_LO +: 2] = tx_type_a[i];
                reg_rdata[TX_EN_B]         = tx_en_a[i];
            end
        end
    end

    p_ep0_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0) |=> (rx_en[0] && tx_en[0] && rx_type[1:0] == 2'd0 && tx_type[1:0] == 2'd0));

    p_hs_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_stall_hs[NUM_EP-1]) |-> rx_en[NUM_EP-1]);

endmodule

// File: tb/sim_usb_ep_ctrl_bank.sv
`timescale 1ns/1ps
module sim_usb_ep_ctrl_bank;
    localparam int NUM_EP = 4;
    localparam int TRAIL  = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  setup_pulse = '0;
    logic [3:0]  setup_stat = '0;
    logic [3:0]  rx_stall_hs, tx_stall_hs, rx_en, tx_en;
    logic [7:0]  rx_type, tx_type;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    usb_ep_ctrl_bank #(.NUM_EP(NUM_EP), .TRAIL_CYC(TRAIL)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .setup_pulse(setup_pulse), .setup_stat(setup_stat),
        .rx_stall_hs(rx_stall_hs), .tx_stall_hs(tx_stall_hs),
        .rx_type(rx_type), .tx_type(tx_type), .rx_en(rx_en), .tx_en(tx_en)
    );

    // {addr, write data, expected read data}
    localparam logic [65:0] VECS [5] = '{
        {2'd1, 32'hFFFF_FFFF, 32'h008D_008D},
        {2'd2, 32'h0088_0009, 32'h0088_0009},
        {2'd0, 32'hFFFF_FFFF, 32'h0081_0081},
        {2'd3, 32'h5A5A_5A5A, 32'h0008_0008},
        {2'd1, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input int ep, input logic stat);
        @(negedge clk);
        setup_pulse[ep] = 1'b1; setup_stat[ep] = stat;
        @(negedge clk);
        setup_pulse[ep] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 / R9 reset state
        for (int i = 0; i < NUM_EP; i++) begin
            rd(2'(i), r);
            check(i == 0 ? "R9 reset ep0" : "R8 reset", r, i == 0 ? 32'h0080_0080 : 32'h0);
        end
        check("R8 reset handshakes", {28'h0, rx_stall_hs | tx_stall_hs}, 32'h0);

        // R7 / R9 / R10 vector table
        for (int v = 0; v < 5; v++) begin
            wr(VECS[v][65:64], VECS[v][63:32]);
            rd(VECS[v][65:64], r);
            check("R7 layout vector", r, VECS[v][31:0]);
        end
        check("R10 type output ep3 tx", {30'h0, tx_type[7:6]}, 32'd2);

        // R1 enable gating
        check("R1 stall without enable", {31'h0, rx_stall_hs[2]}, 32'd0);
        wr(2'd2, 32'h0088_0089);
        check("R1 stall with enable", {31'h0, rx_stall_hs[2]}, 32'd1);

        // R2 persistence on ep0
        repeat (20) @(negedge clk);
        rd(2'd0, r);
        check("R2 persistence", r, 32'h0081_0081);
        check("R1 ep0 handshakes", {30'h0, rx_stall_hs[0], tx_stall_hs[0]}, 32'd3);

        // R3 control clear, R4 write rejected while status high
        pulse(0, 1'b1);
        rd(2'd0, r);
        check("R3 setup clears control", r, 32'h0080_0080);
        wr(2'd0, 32'h0001_0001);
        rd(2'd0, r);
        check("R4 write ignored while status", r, 32'h0080_0080);

        // R3 bulk endpoint kept
        wr(2'd1, 32'h0089_0089);
        pulse(1, 1'b1);
        rd(2'd1, r);
        check("R3 bulk keeps stall", r, 32'h0089_0089);
        check("R3 bulk handshake", {31'h0, tx_stall_hs[1]}, 32'd1);
        setup_stat[1] = 1'b0;

        // R5 trailing window
        @(negedge clk);
        setup_stat[0] = 1'b0;
        repeat (25) @(negedge clk);
        wr(2'd0, 32'h0001_0001);
        rd(2'd0, r);
        check("R5 write ignored in window", r, 32'h0080_0080);
        repeat (TRAIL + 10) @(negedge clk);
        wr(2'd0, 32'h0001_0001);
        rd(2'd0, r);
        check("R5 write after window", r, 32'h0081_0081);

        // R3 mixed types on ep3: rx control, tx bulk
        wr(2'd3, 32'h0089_0081);
        pulse(3, 1'b0);
        rd(2'd3, r);
        check("R3 mixed directions", r, 32'h0089_0080);

        // R6 same-cycle conflict on ep0
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h0001_0001;
        setup_pulse[0] = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; setup_pulse[0] = 1'b0;
        rd(2'd0, r);
        check("R6 hardware wins", r, 32'h0080_0080);

        // R9 ep0 type/enable locked
        wr(2'd0, 32'h000C_000C);
        rd(2'd0, r);
        check("R9 ep0 locked", r, 32'h0080_0080);
        check("R9 ep0 enables", {30'h0, rx_en[0], tx_en[0]}, 32'd3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule